// File: doc/BRIEF.md
# Dual-Issue Reservation Station Lane

This block is one issue lane of an out-of-order integer core. It keeps up to eight dispatched instructions waiting for their operands. An instruction may hold an ALU part, an address-generation part, or both. The two parts share one entry and leave it independently: the ALU part goes to the lane's single ALU issue port and the address part to its single AGU issue port. The entry is released once every part it was given has issued.

Every waiting operand compares its tag against all result broadcast ports of the core, not only the lane's own units. A producer announces its destination tag one cycle before the result data, and the data arrives on the same port. An operand whose tag is seen can be selected in that same cycle. Its value then reaches the issue port in the next cycle, taken straight from the broadcast data bus. An operand selected later uses the value the entry captured. When several entries are ready, each unit takes the one dispatched earliest. A flush empties the lane in one cycle.

The dispatcher must hand over an operand as ready, with its value, if its producer's tag has already been broadcast. Sources are numbered 0, 1 and 2. Sources 0 and 1 are the ALU operands A and B. Source 2 is the address base. The address offset is an immediate value.

Top module: `rs_lane`

## Requirements
- R1: After reset the lane is empty: `disp_ready`=1, `lane_full`=0, `alu_iss_vld`=0 and `agu_iss_vld`=0.
- R2: An ALU part whose sources 0 and 1 are dispatched ready is accepted at the clock edge that samples the dispatch. It appears on the ALU issue port one cycle after the following edge, with its op, destination tag and operand values. It issues exactly once.
- R3: An address part issues on the AGU port with its op, destination tag, base value (source 2) and offset (immediate). The ALU and AGU parts of one entry may issue in the same cycle.
- R4: A dispatch with neither part enabled stores nothing and causes no issue.
- R5: The lane holds 8 entries. While all 8 are occupied, `lane_full`=1 and `disp_ready`=0, and a dispatch is ignored.
- R6: A tag on any broadcast port with its valid bit set wakes every waiting operand that carries that tag. The operand can be selected in that cycle. In the next cycle it issues with the data that the same port carries in that cycle.
- R7: An operand woken by a tag but selected one or more cycles later issues with the data broadcast in the cycle after the tag, even after the bus has changed.
- R8: When several entries are ready for one unit, the entry dispatched earliest is issued first, whatever slot it occupies.
- R9: An entry stays occupied until all of its enabled parts have issued. It is free in the cycle after its last part is selected.
- R10: A flush empties every entry in one cycle and suppresses any issue in the following cycle. Operands that were waiting never issue afterwards, and the lane accepts new dispatches right away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the lane |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Lane can accept a dispatch |
| disp_alu_en | input | 1 | Instruction has an ALU part |
| disp_alu_op | input | OP_W | ALU operation code |
| disp_alu_dst | input | TAG_W | ALU result tag |
| disp_agu_en | input | 1 | Instruction has an address part |
| disp_agu_op | input | OP_W | Address operation code |
| disp_agu_dst | input | TAG_W | Address result tag |
| disp_src_rdy | input | 3 | Per source: value already known |
| disp_src_tag | input | 3 x TAG_W | Per source producer tag |
| disp_src_val | input | 3 x DATA_W | Per source value when ready |
| disp_imm | input | DATA_W | Address offset |
| bc_tag_vld | input | NPORT | Per broadcast port: tag valid this cycle |
| bc_tag | input | NPORT x TAG_W | Broadcast tags |
| bc_data | input | NPORT x DATA_W | Broadcast data, one cycle after its tag |
| alu_iss_vld | output | 1 | ALU issue valid |
| alu_iss_op | output | OP_W | ALU issue op |
| alu_iss_dst | output | TAG_W | ALU issue result tag |
| alu_iss_a | output | DATA_W | ALU operand A |
| alu_iss_b | output | DATA_W | ALU operand B |
| agu_iss_vld | output | 1 | AGU issue valid |
| agu_iss_op | output | OP_W | AGU issue op |
| agu_iss_dst | output | TAG_W | AGU issue result tag |
| agu_iss_base | output | DATA_W | Address base |
| agu_iss_ofs | output | DATA_W | Address offset |
| lane_full | output | 1 | All entries occupied |

## Verification
A corrupted operand state shows up on the issue data. A capture that was missed issues the garbage that follows on the bus one cycle later. A forward that was skipped issues a stale value in the very cycle of issue. A wrong age order swaps the destination tags of back-to-back issues within one to three cycles of the wakeup. A lost or stuck part is visible through `lane_full` on a lane that was filled on purpose, and it shows in the cycle after the part should have left.

// File: rtl/rsl_pkg.sv
// Shared types for the reservation station lane.
// Assumes: three sources per instruction, fixed roles (A, B, base).
package rsl_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_A    = 0;
    localparam int SRC_B    = 1;
    localparam int SRC_BASE = 2;

    // Operand life cycle: waiting for tag, tag seen (data on bus now), value held.
    typedef enum logic [1:0] {
        OPS_WAIT = 2'd0,
        OPS_PEND = 2'd1,
        OPS_HELD = 2'd2
    } opnd_state_e;
endpackage

// File: rtl/rsl_operand.sv
// One source operand of one entry: snoops all broadcast ports, tracks
// wait/pend/held, captures the data one cycle after its tag match.
// Assumes: a load never coincides with a valid match of the same tag.
module rsl_operand
    import rsl_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int NPORT  = 3,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          load,
    input  logic                          ld_rdy,
    input  logic [TAG_W-1:0]              ld_tag,
    input  logic [DATA_W-1:0]             ld_val,
    input  logic [NPORT-1:0]              bc_tag_vld,
    input  logic [NPORT-1:0][TAG_W-1:0]   bc_tag,
    input  logic [NPORT-1:0][DATA_W-1:0]  bc_data,
    output opnd_state_e                   st,
    output logic [PW-1:0]                 pend_port,
    output logic [PW-1:0]                 hit_port,
    output logic [DATA_W-1:0]             val,
    output logic                          hit_now
);
    logic [TAG_W-1:0] tag_q;

    // Lowest broadcast port whose tag matches a waiting operand.
    always_comb begin
        hit_now  = 1'b0;
        hit_port = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (st == OPS_WAIT && bc_tag_vld[p] && bc_tag[p] == tag_q) begin
                hit_now  = 1'b1;
                hit_port = PW'(p);
            end
        end
    end

    // State and capture register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st        <= OPS_WAIT;
            pend_port <= '0;
        end else if (load) begin
            st    <= ld_rdy ? OPS_HELD : OPS_WAIT;
            tag_q <= ld_tag;
            val   <= ld_val;
        end else if (hit_now) begin
            st        <= OPS_PEND;
            pend_port <= hit_port;
        end else if (st == OPS_PEND) begin
            st  <= OPS_HELD;
            val <= bc_data[pend_port];
        end
    end
endmodule

// File: rtl/rsl_age_pick.sv
// Dispatch-order age matrix shared by both units; grants the oldest
// requesting entry per unit. older[i][j]=1 means entry i was dispatched before j.
// Assumes: at most one allocation per cycle, into a free slot.
module rsl_age_pick #(
    parameter int DEPTH = 8,
    parameter int NUNIT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             alloc,
    input  logic [DEPTH-1:0]             valid,
    input  logic [NUNIT-1:0][DEPTH-1:0]  req,
    output logic [NUNIT-1:0][DEPTH-1:0]  gnt
);
    logic [DEPTH-1:0][DEPTH-1:0] older;

    // New entry is younger than every occupied entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc[i])
                        older[i][j] <= 1'b0;
                    else if (alloc[j] && i != j)
                        older[i][j] <= valid[i];
                end
            end
        end
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        // Grant an entry when no older entry requests the same unit.
        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                logic blocked;
                blocked = 1'b0;
                for (int j = 0; j < DEPTH; j++)
                    if (j != i && req[u][j] && older[j][i])
                        blocked = 1'b1;
                gnt[u][i] = req[u][i] && !blocked;
            end
        end
    end
endmodule

// File: rtl/rsl_issue.sv
// Issue register for one unit: latches the granted entry's fields and
// operand values; a tag-cycle wakeup is forwarded from the bus one cycle later.
// Assumes: gnt is one-hot or zero.
module rsl_issue
    import rsl_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NS     = 2,
    parameter int SIDE_W = 10,
    parameter int DATA_W = 16,
    parameter int NPORT  = 3,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic [DEPTH-1:0]                      gnt,
    input  logic [DEPTH-1:0][SIDE_W-1:0]          side,
    input  logic [DEPTH-1:0][NS-1:0][1:0]         st,
    input  logic [DEPTH-1:0][NS-1:0][DATA_W-1:0]  val,
    input  logic [DEPTH-1:0][NS-1:0][PW-1:0]      pp,
    input  logic [DEPTH-1:0][NS-1:0][PW-1:0]      hp,
    input  logic [NPORT-1:0][DATA_W-1:0]          bc_data,
    output logic                                  iss_vld,
    output logic [SIDE_W-1:0]                     iss_side,
    output logic [NS-1:0][DATA_W-1:0]             iss_opnd
);
    logic                         any;
    logic [SIDE_W-1:0]            s_side;
    logic [NS-1:0][1:0]           s_st;
    logic [NS-1:0][DATA_W-1:0]    s_val;
    logic [NS-1:0][PW-1:0]        s_pp, s_hp;
    logic [NS-1:0]                fwd_q;
    logic [NS-1:0][PW-1:0]        port_q;
    logic [NS-1:0][DATA_W-1:0]    val_q;

    // One-hot OR mux of the granted entry.
    always_comb begin
        any = 1'b0; s_side = '0; s_st = '0; s_val = '0; s_pp = '0; s_hp = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (gnt[i]) begin
                any    = 1'b1;
                s_side = s_side | side[i];
                s_st   = s_st | st[i];
                s_val  = s_val | val[i];
                s_pp   = s_pp | pp[i];
                s_hp   = s_hp | hp[i];
            end
        end
    end

    // Issue register; operand source is held value, bus now, or bus next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld  <= 1'b0;
            iss_side <= '0;
            fwd_q    <= '0;
            port_q   <= '0;
            val_q    <= '0;
        end else begin
            iss_vld <= any && !flush;
            if (any) begin
                iss_side <= s_side;
                for (int s = 0; s < NS; s++) begin
                    port_q[s] <= s_hp[s];
                    fwd_q[s]  <= (s_st[s] == OPS_WAIT);
                    if (s_st[s] == OPS_HELD)
                        val_q[s] <= s_val[s];
                    else
                        val_q[s] <= bc_data[s_pp[s]];
                end
            end
        end
    end

    // Late forward of data that trails its tag by one cycle.
    always_comb begin
        for (int s = 0; s < NS; s++)
            iss_opnd[s] = fwd_q[s] ? bc_data[port_q[s]] : val_q[s];
    end
endmodule

// File: rtl/rs_lane.sv
// Reservation station lane: eight entries, each with an optional ALU part and
// an optional address part, issuing to one ALU and one AGU port, oldest first.
// Assumes: sources already broadcast are dispatched ready; data trails tag by one cycle.
module rs_lane
    import rsl_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NPORT  = 3,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          disp_valid,
    output logic                          disp_ready,
    input  logic                          disp_alu_en,
    input  logic [OP_W-1:0]               disp_alu_op,
    input  logic [TAG_W-1:0]              disp_alu_dst,
    input  logic                          disp_agu_en,
    input  logic [OP_W-1:0]               disp_agu_op,
    input  logic [TAG_W-1:0]              disp_agu_dst,
    input  logic [NSRC-1:0]               disp_src_rdy,
    input  logic [NSRC-1:0][TAG_W-1:0]    disp_src_tag,
    input  logic [NSRC-1:0][DATA_W-1:0]   disp_src_val,
    input  logic [DATA_W-1:0]             disp_imm,
    input  logic [NPORT-1:0]              bc_tag_vld,
    input  logic [NPORT-1:0][TAG_W-1:0]   bc_tag,
    input  logic [NPORT-1:0][DATA_W-1:0]  bc_data,
    output logic                          alu_iss_vld,
    output logic [OP_W-1:0]               alu_iss_op,
    output logic [TAG_W-1:0]              alu_iss_dst,
    output logic [DATA_W-1:0]             alu_iss_a,
    output logic [DATA_W-1:0]             alu_iss_b,
    output logic                          agu_iss_vld,
    output logic [OP_W-1:0]               agu_iss_op,
    output logic [TAG_W-1:0]              agu_iss_dst,
    output logic [DATA_W-1:0]             agu_iss_base,
    output logic [DATA_W-1:0]             agu_iss_ofs,
    output logic                          lane_full
);
    localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int ASIDE  = OP_W + TAG_W;
    localparam int GSIDE  = OP_W + TAG_W + DATA_W;

    logic [DEPTH-1:0]             alu_pend, agu_pend, valid, free_oh, alloc;
    logic [DEPTH-1:0]             req_alu, req_agu, gnt_alu, gnt_agu;
    logic [DEPTH-1:0][ASIDE-1:0]  alu_side;
    logic [DEPTH-1:0][GSIDE-1:0]  agu_side;
    logic [DEPTH-1:0][OP_W-1:0]   a_op_q, g_op_q;
    logic [DEPTH-1:0][TAG_W-1:0]  a_dst_q, g_dst_q;
    logic [DEPTH-1:0][DATA_W-1:0] imm_q;

    logic [DEPTH-1:0][NSRC-1:0][1:0]        e_st;
    logic [DEPTH-1:0][NSRC-1:0][PW-1:0]     e_pp, e_hp;
    logic [DEPTH-1:0][NSRC-1:0][DATA_W-1:0] e_val;
    logic [DEPTH-1:0][NSRC-1:0]             e_hit, e_ok;

    logic [DEPTH-1:0][1:0][1:0]        a_st;
    logic [DEPTH-1:0][1:0][PW-1:0]     a_pp, a_hp;
    logic [DEPTH-1:0][1:0][DATA_W-1:0] a_val;
    logic [DEPTH-1:0][0:0][1:0]        g_st;
    logic [DEPTH-1:0][0:0][PW-1:0]     g_pp, g_hp;
    logic [DEPTH-1:0][0:0][DATA_W-1:0] g_val;

    logic [1:0][DEPTH-1:0] req_u, gnt_u;
    logic [ASIDE-1:0]            alu_side_q;
    logic [GSIDE-1:0]            agu_side_q;
    logic [1:0][DATA_W-1:0]      alu_opnd;
    logic [0:0][DATA_W-1:0]      agu_opnd;

    assign valid      = alu_pend | agu_pend;
    assign lane_full  = &valid;
    assign disp_ready = !lane_full;

    // Lowest-numbered free slot.
    always_comb begin
        free_oh = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid[i]) begin
                free_oh    = '0;
                free_oh[i] = 1'b1;
            end
    end

    assign alloc = (disp_valid && !flush && (disp_alu_en || disp_agu_en)) ? free_oh : '0;

    // Part-pending flags: set on allocation, cleared on grant or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            alu_pend <= '0;
            agu_pend <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc[i]) begin
                    alu_pend[i] <= disp_alu_en;
                    agu_pend[i] <= disp_agu_en;
                end else begin
                    if (gnt_alu[i]) alu_pend[i] <= 1'b0;
                    if (gnt_agu[i]) agu_pend[i] <= 1'b0;
                end
            end
        end
    end

    // Per-entry payload captured at allocation.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++)
            if (alloc[i]) begin
                a_op_q[i]  <= disp_alu_op;
                a_dst_q[i] <= disp_alu_dst;
                g_op_q[i]  <= disp_agu_op;
                g_dst_q[i] <= disp_agu_dst;
                imm_q[i]   <= disp_imm;
            end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            rsl_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NPORT(NPORT)) u_opnd (
                .clk(clk), .rst_n(rst_n), .clr(flush), .load(alloc[i]),
                .ld_rdy(disp_src_rdy[s]), .ld_tag(disp_src_tag[s]), .ld_val(disp_src_val[s]),
                .bc_tag_vld(bc_tag_vld), .bc_tag(bc_tag), .bc_data(bc_data),
                .st(e_st[i][s]), .pend_port(e_pp[i][s]), .hit_port(e_hp[i][s]),
                .val(e_val[i][s]), .hit_now(e_hit[i][s])
            );
            assign e_ok[i][s] = (e_st[i][s] != OPS_WAIT) || e_hit[i][s];
        end
        assign req_alu[i]  = alu_pend[i] && e_ok[i][SRC_A] && e_ok[i][SRC_B];
        assign req_agu[i]  = agu_pend[i] && e_ok[i][SRC_BASE];
        assign alu_side[i] = {a_op_q[i], a_dst_q[i]};
        assign agu_side[i] = {g_op_q[i], g_dst_q[i], imm_q[i]};
        assign a_st[i]  = e_st[i][SRC_B:SRC_A];
        assign a_pp[i]  = e_pp[i][SRC_B:SRC_A];
        assign a_hp[i]  = e_hp[i][SRC_B:SRC_A];
        assign a_val[i] = e_val[i][SRC_B:SRC_A];
        assign g_st[i][0]  = e_st[i][SRC_BASE];
        assign g_pp[i][0]  = e_pp[i][SRC_BASE];
        assign g_hp[i][0]  = e_hp[i][SRC_BASE];
        assign g_val[i][0] = e_val[i][SRC_BASE];
    end

    assign req_u   = {req_agu, req_alu};
    assign gnt_alu = gnt_u[0];
    assign gnt_agu = gnt_u[1];

    rsl_age_pick #(.DEPTH(DEPTH), .NUNIT(2)) u_age (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .valid(valid), .req(req_u), .gnt(gnt_u)
    );

    rsl_issue #(.DEPTH(DEPTH), .NS(2), .SIDE_W(ASIDE), .DATA_W(DATA_W), .NPORT(NPORT)) u_alu_iss (
        .clk(clk), .rst_n(rst_n), .flush(flush), .gnt(gnt_alu), .side(alu_side),
        .st(a_st), .val(a_val), .pp(a_pp), .hp(a_hp), .bc_data(bc_data),
        .iss_vld(alu_iss_vld), .iss_side(alu_side_q), .iss_opnd(alu_opnd)
    );

    rsl_issue #(.DEPTH(DEPTH), .NS(1), .SIDE_W(GSIDE), .DATA_W(DATA_W), .NPORT(NPORT)) u_agu_iss (
        .clk(clk), .rst_n(rst_n), .flush(flush), .gnt(gnt_agu), .side(agu_side),
        .st(g_st), .val(g_val), .pp(g_pp), .hp(g_hp), .bc_data(bc_data),
        .iss_vld(agu_iss_vld), .iss_side(agu_side_q), .iss_opnd(agu_opnd)
    );

    assign {alu_iss_op, alu_iss_dst}              = alu_side_q;
    assign {agu_iss_op, agu_iss_dst, agu_iss_ofs} = agu_side_q;
    assign alu_iss_a    = alu_opnd[0];
    assign alu_iss_b    = alu_opnd[1];
    assign agu_iss_base = agu_opnd[0];
endmodule

// File: rtl/rs_lane_chk.sv
// Property checker for rs_lane, attached by bind.
// Assumes: sampled on the lane clock, disabled during reset.
module rs_lane_chk #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             lane_full,
    input logic             alu_iss_vld,
    input logic             agu_iss_vld,
    input logic [DEPTH-1:0] valid,
    input logic [DEPTH-1:0] gnt_alu,
    input logic [DEPTH-1:0] gnt_agu,
    input logic [DEPTH-1:0] alu_pend,
    input logic [DEPTH-1:0] agu_pend
);
    // R10: a flush leaves the lane empty and silent on the next cycle.
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!alu_iss_vld && !agu_iss_vld && !lane_full));

    // R5: a full lane never gains an occupied entry.
    a_r5_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        lane_full |=> ($countones(valid) <= $past($countones(valid))));

    // R8: at most one entry is granted per unit.
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_alu) && $onehot0(gnt_agu));

    // R9: only a still-pending part can be granted.
    a_r9_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_alu & ~alu_pend) == '0) && ((gnt_agu & ~agu_pend) == '0));

    // R2: an ALU issue follows a grant of the previous cycle.
    a_r2_issue_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_alu && !flush) |=> alu_iss_vld);

    // R9: a full lane without grants or flush stays full.
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_full && !flush && gnt_alu == '0 && gnt_agu == '0) |=> lane_full);
endmodule

bind rs_lane rs_lane_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lane_full(lane_full),
    .alu_iss_vld(alu_iss_vld), .agu_iss_vld(agu_iss_vld), .valid(valid),
    .gnt_alu(gnt_alu), .gnt_agu(gnt_agu), .alu_pend(alu_pend), .agu_pend(agu_pend)
);

// File: tb/tb_rs_lane.sv
`timescale 1ns/1ps
module tb_rs_lane;
    localparam int NPORT  = 3;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;

    logic clk = 1'b0;
    logic rst_n, flush, disp_valid, disp_ready, disp_alu_en, disp_agu_en;
    logic [OP_W-1:0] disp_alu_op, disp_agu_op;
    logic [TAG_W-1:0] disp_alu_dst, disp_agu_dst;
    logic [2:0] disp_src_rdy;
    logic [2:0][TAG_W-1:0] disp_src_tag;
    logic [2:0][DATA_W-1:0] disp_src_val;
    logic [DATA_W-1:0] disp_imm;
    logic [NPORT-1:0] bc_tag_vld;
    logic [NPORT-1:0][TAG_W-1:0] bc_tag;
    logic [NPORT-1:0][DATA_W-1:0] bc_data;
    logic alu_iss_vld, agu_iss_vld, lane_full;
    logic [OP_W-1:0] alu_iss_op, agu_iss_op;
    logic [TAG_W-1:0] alu_iss_dst, agu_iss_dst;
    logic [DATA_W-1:0] alu_iss_a, alu_iss_b, agu_iss_base, agu_iss_ofs;

    int checks = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rs_lane dut (.*);

    function automatic logic [DATA_W-1:0] fdat(input int tag);
        return DATA_W'(16'hA000 + tag * 16'h11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        flush = 0; disp_valid = 0; disp_alu_en = 0; disp_agu_en = 0;
        disp_alu_op = '0; disp_agu_op = '0; disp_alu_dst = '0; disp_agu_dst = '0;
        disp_src_rdy = '0; disp_src_tag = '0; disp_src_val = '0; disp_imm = '0;
        bc_tag_vld = '0; bc_tag = '0;
        for (int p = 0; p < NPORT; p++) bc_data[p] = 16'hDEAD;
    endtask

    task automatic next();
        @(negedge clk);
        idle_in();
    endtask

    task automatic settle();
        #4;
    endtask

    task automatic disp(input logic ae, input logic ge, input int aop, input int adst,
                        input int gop, input int gdst, input logic [2:0] rdy,
                        input int t0, input int t2, input int v0, input int v1,
                        input int v2, input int imm);
        disp_valid = 1; disp_alu_en = ae; disp_agu_en = ge;
        disp_alu_op = OP_W'(aop); disp_alu_dst = TAG_W'(adst);
        disp_agu_op = OP_W'(gop); disp_agu_dst = TAG_W'(gdst);
        disp_src_rdy = rdy;
        disp_src_tag[0] = TAG_W'(t0); disp_src_tag[1] = '0; disp_src_tag[2] = TAG_W'(t2);
        disp_src_val[0] = DATA_W'(v0); disp_src_val[1] = DATA_W'(v1); disp_src_val[2] = DATA_W'(v2);
        disp_imm = DATA_W'(imm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R1 ready", disp_ready, 1);
        chk("R1 full", lane_full, 0);
        chk("R1 alu vld", alu_iss_vld, 0);
        chk("R1 agu vld", agu_iss_vld, 0);
        next();

        // R2 R3 R4: all four part combinations with ready operands.
        for (int k = 0; k < 4; k++) begin
            disp(k[0], k[1], k + 1, 10 + k, k + 5, 20 + k, 3'b111, 0, 0,
                 16'h1000 + k, 16'h2000 + k, 16'h3000 + k, 16'h40 + k);
            next();
            settle(); chk("R2 no early issue", alu_iss_vld, 0); next();
            settle();
            if (k == 0) begin
                chk("R4 none alu", alu_iss_vld, 0);
                chk("R4 none agu", agu_iss_vld, 0);
            end else begin
                chk("R2 alu vld", alu_iss_vld, k[0]);
                chk("R3 agu vld", agu_iss_vld, k[1]);
                if (k[0]) begin
                    chk("R2 op", alu_iss_op, k + 1);
                    chk("R2 dst", alu_iss_dst, 10 + k);
                    chk("R2 a", alu_iss_a, 16'h1000 + k);
                    chk("R2 b", alu_iss_b, 16'h2000 + k);
                end
                if (k[1]) begin
                    chk("R3 op", agu_iss_op, k + 5);
                    chk("R3 dst", agu_iss_dst, 20 + k);
                    chk("R3 base", agu_iss_base, 16'h3000 + k);
                    chk("R3 ofs", agu_iss_ofs, 16'h40 + k);
                end
            end
            next();
            settle();
            chk("R2 once alu", alu_iss_vld, 0);
            chk("R3 once agu", agu_iss_vld, 0);
            chk("R4 lane empty", lane_full, 0);
            next();
        end

        // R5: fill with waiting ALU entries, tags 1..8.
        for (int i = 0; i < 8; i++) begin
            disp(1, 0, 1, 32 + i, 0, 0, 3'b010, 1 + i, 0, 0, 16'h100 + i, 0, 0);
            settle(); chk("R5 ready while filling", disp_ready, 1); next();
        end
        disp(1, 0, 9, 63, 0, 0, 3'b111, 0, 0, 1, 2, 3, 0);
        settle();
        chk("R5 full", lane_full, 1);
        chk("R5 not ready", disp_ready, 0);
        next();
        for (int c = 0; c < 3; c++) begin
            settle(); chk("R5 ignored dispatch", alu_iss_vld, 0); next();
        end

        // R6 R7: wake groups of up to three, ports rotated; issue oldest first.
        for (int g = 0; g < 3; g++) begin
            int n;
            n = (g == 2) ? 2 : 3;
            for (int j = 0; j < n; j++) begin
                bc_tag_vld[(j + g) % 3] = 1;
                bc_tag[(j + g) % 3] = TAG_W'(3 * g + 1 + j);
            end
            settle(); chk("R6 idle before wake", alu_iss_vld, 0); next();
            for (int j = 0; j < n; j++) bc_data[(j + g) % 3] = fdat(3 * g + 1 + j);
            settle();
            chk("R6 fwd vld", alu_iss_vld, 1);
            chk("R6 fwd dst", alu_iss_dst, 32 + 3 * g);
            chk("R6 fwd a", alu_iss_a, fdat(3 * g + 1));
            chk("R6 fwd b", alu_iss_b, 16'h100 + 3 * g);
            if (g == 0) chk("R9 freed after issue", lane_full, 0);
            next();
            for (int j = 1; j < n; j++) begin
                settle();
                chk("R7 vld", alu_iss_vld, 1);
                chk("R7 dst", alu_iss_dst, 32 + 3 * g + j);
                chk("R7 captured a", alu_iss_a, fdat(3 * g + 1 + j));
                next();
            end
            settle(); chk("R6 group done", alu_iss_vld, 0); next();
        end

        // R8: age beats slot index (C lands in slot 0, older B in slot 1).
        disp(1, 0, 1, 40, 0, 0, 3'b111, 0, 0, 5, 6, 0, 0); next();
        disp(1, 0, 1, 41, 0, 0, 3'b010, 9, 0, 0, 7, 0, 0); next();
        next(); next();
        disp(1, 0, 1, 42, 0, 0, 3'b010, 10, 0, 0, 7, 0, 0); next();
        disp(1, 0, 1, 43, 0, 0, 3'b010, 11, 0, 0, 7, 0, 0); next();
        bc_tag_vld = 3'b111;
        bc_tag[2] = TAG_W'(9); bc_tag[1] = TAG_W'(10); bc_tag[0] = TAG_W'(11);
        next();
        bc_data[2] = fdat(9); bc_data[1] = fdat(10); bc_data[0] = fdat(11);
        for (int j = 0; j < 3; j++) begin
            settle();
            chk("R8 order dst", alu_iss_dst, 41 + j);
            chk("R8 order a", alu_iss_a, fdat(9 + j));
            next();
        end

        // R9 R3: dual entry, ALU ready, address base waiting on tag 20.
        disp(1, 1, 2, 50, 7, 51, 3'b011, 0, 20, 16'h55, 16'h66, 0, 16'h77); next();
        next();
        settle();
        chk("R9 alu part", alu_iss_vld, 1);
        chk("R9 alu dst", alu_iss_dst, 50);
        chk("R9 agu waits", agu_iss_vld, 0);
        next();
        for (int i = 0; i < 7; i++) begin
            disp(1, 0, 3, 52 + i, 0, 0, 3'b010, 21 + i, 0, 0, 1, 0, 0); next();
        end
        settle(); chk("R9 entry still held", lane_full, 1); next();
        bc_tag_vld[1] = 1; bc_tag[1] = TAG_W'(20); next();
        bc_data[1] = fdat(20);
        settle();
        chk("R3 agu vld", agu_iss_vld, 1);
        chk("R3 agu dst", agu_iss_dst, 51);
        chk("R3 agu op", agu_iss_op, 7);
        chk("R6 agu base", agu_iss_base, fdat(20));
        chk("R3 agu ofs", agu_iss_ofs, 16'h77);
        chk("R9 released", lane_full, 0);
        next();

        // R10: flush with a wakeup in the same cycle.
        flush = 1; bc_tag_vld[0] = 1; bc_tag[0] = TAG_W'(21); next();
        bc_data[0] = fdat(21);
        settle();
        chk("R10 no issue", alu_iss_vld, 0);
        chk("R10 empty", lane_full, 0);
        chk("R10 ready", disp_ready, 1);
        next();
        bc_tag_vld = 3'b011; bc_tag[0] = TAG_W'(22); bc_tag[1] = TAG_W'(23); next();
        for (int c = 0; c < 3; c++) begin
            settle(); chk("R10 stale never issues", alu_iss_vld, 0); next();
        end
        disp(1, 0, 4, 60, 0, 0, 3'b111, 0, 0, 16'h0ABC, 16'h0DEF, 0, 0); next();
        next();
        settle();
        chk("R10 accepts after flush", alu_iss_vld, 1);
        chk("R10 dst after flush", alu_iss_dst, 60);
        next();

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule